// File: doc/BRIEF.md
# Byte Mask, Extract and Insert Unit

This unit is the byte-manipulation slice of an integer execution pipe. It takes a 7-bit function code, a 64-bit operand A and a second operand B, and returns a 64-bit result. B is either the register operand or an 8-bit literal, zero-extended. It covers three logical and arithmetic shifts, and the paired low/high forms of masking, extracting and inserting at byte, word, longword and quadword sizes. These pairs are the pieces a compiler combines into unaligned loads and stores. It also has two byte-wise clear operations driven by an 8-bit byte selector.

The byte offset is taken from B bits 2:0 and the shift count from B bits 5:0. The size of the field comes from function bits 5:4 (0 byte, 1 word, 2 longword, 3 quadword). The high forms behave specially at byte offset zero. The result and an illegal-function flag are registered, so they appear one clock after the inputs.

Top module: `bmx_unit`

## Requirements
- R1: While reset is low, result_o and illegal_o are zero. Otherwise they show, one clock edge later, the outcome of the inputs present at that edge.
- R2: Code 0x39 shifts A left, 0x34 shifts it right logically and 0x3c shifts it right arithmetically. Each shifts by B[5:0], and a count of zero returns A.
- R3: Mask-low codes 0x02/0x12/0x22/0x32 (field of 8/16/32/64 bits) clear in A the field shifted left by 8*B[2:0]. Bits shifted beyond bit 63 are dropped.
- R4: Mask-high codes 0x52/0x62/0x72 (16/32/64 bits) clear in A the field shifted right by 64-8*B[2:0]. At offset zero, A is returned unchanged.
- R5: Extract-low codes 0x06/0x16/0x26/0x36 shift A right by 8*B[2:0] and keep the low 8/16/32/64 bits.
- R6: Extract-high codes 0x5a/0x6a/0x7a shift A left by (64-8*B[2:0]) mod 64 and keep the low 16/32/64 bits. At offset zero, this gives the low field of A unshifted.
- R7: Insert-low codes 0x0b/0x1b/0x2b/0x3b shift the low 8/16/32/64 bits of A left by 8*B[2:0].
- R8: Insert-high codes 0x57/0x67/0x77 shift the low 16/32/64 bits of A right by 64-8*B[2:0]. At offset zero, the result is zero.
- R9: Code 0x30 clears byte i of A for each set bit i of B[7:0]. Code 0x31 clears byte i for each clear bit i.
- R10: When use_lit_i is high, lit_i zero-extended replaces b_i for every code, and b_i has no effect.
- R11: Any other code gives a zero result with illegal_o high. Every listed code gives illegal_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| func_i | input | 7 | Function code |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Register operand B |
| lit_i | input | 8 | Literal operand |
| use_lit_i | input | 1 | Select literal instead of b_i |
| result_o | output | 64 | Registered result |
| illegal_o | output | 1 | Registered unknown-code flag |

## Verification
Every code is applied at all eight byte offsets with three operands: an ascending byte ramp, a pattern with the sign bit set, and a random value. The ramp makes a wrong byte position visible. The negative pattern separates arithmetic from logical right shifts, and the random value catches cross-byte leakage. The shifts get a full 0 to 63 count sweep. The byte-clear codes get the empty, full and alternating selectors. Each case is repeated in literal mode with random garbage on b_i, which shows that the register operand is really ignored. A few undefined codes sit next to valid ones in the code space, so the illegal flag is tested on codes one bit away from legal ones.

// File: rtl/bmx_pkg.sv
package bmx_pkg;

    localparam logic [6:0] FN_SLL    = 7'h39;
    localparam logic [6:0] FN_SRL    = 7'h34;
    localparam logic [6:0] FN_SRA    = 7'h3c;
    localparam logic [6:0] FN_ZAP    = 7'h30;
    localparam logic [6:0] FN_ZAPNOT = 7'h31;

    typedef enum logic [3:0] {
        K_SLL, K_SRL, K_SRA,
        K_MSKL, K_MSKH,
        K_EXTL, K_EXTH,
        K_INSL, K_INSH,
        K_ZAP, K_ZAPN,
        K_BAD
    } op_kind_e;

    // size: 0 byte, 1 word, 2 longword, 3 quadword
    typedef struct packed {
        op_kind_e   kind;
        logic [1:0] size;
    } dec_t;

endpackage

// File: rtl/bmx_decode.sv
module bmx_decode
    import bmx_pkg::*;
(
    input  logic [6:0] func,
    output dec_t       dec
);

    always_comb begin
        dec.size = func[5:4];
        case (func)
            FN_SLL:                          dec.kind = K_SLL;
            FN_SRL:                          dec.kind = K_SRL;
            FN_SRA:                          dec.kind = K_SRA;
            7'h02, 7'h12, 7'h22, 7'h32:      dec.kind = K_MSKL;
            7'h52, 7'h62, 7'h72:             dec.kind = K_MSKH;
            7'h06, 7'h16, 7'h26, 7'h36:      dec.kind = K_EXTL;
            7'h5a, 7'h6a, 7'h7a:             dec.kind = K_EXTH;
            7'h0b, 7'h1b, 7'h2b, 7'h3b:      dec.kind = K_INSL;
            7'h57, 7'h67, 7'h77:             dec.kind = K_INSH;
            FN_ZAP:                          dec.kind = K_ZAP;
            FN_ZAPNOT:                       dec.kind = K_ZAPN;
            default:                         dec.kind = K_BAD;
        endcase
    end

endmodule

// File: rtl/bmx_szmask.sv
module bmx_szmask #(
    parameter int DATA_W = 64,
    localparam int BYTES = DATA_W / 8
) (
    input  logic [1:0]        size,
    output logic [BYTES-1:0]  byte_mask,
    output logic [DATA_W-1:0] bit_mask
);

    always_comb begin
        for (int i = 0; i < BYTES; i++) begin
            byte_mask[i] = (i < (32'sd1 <<< size));
        end
    end

    for (genvar g = 0; g < BYTES; g++) begin : g_expand
        assign bit_mask[g*8 +: 8] = {8{byte_mask[g]}};
    end

endmodule

// File: rtl/bmx_bytemask.sv
module bmx_bytemask #(
    parameter int DATA_W = 64,
    localparam int BYTES = DATA_W / 8,
    localparam int OFS_W = $clog2(BYTES)
) (
    input  logic [DATA_W-1:0] a,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [BYTES-1:0]  fld_bytes,
    input  logic [BYTES-1:0]  sel_bytes,
    output logic [DATA_W-1:0] msk_lo,
    output logic [DATA_W-1:0] msk_hi,
    output logic [DATA_W-1:0] zap,
    output logic [DATA_W-1:0] zap_not
);

    // Field placed at the byte offset in a double-width window:
    // the lower half is the low mask, the spill is the high mask.
    logic [2*BYTES-1:0] span;
    logic [DATA_W-1:0]  clr_lo, clr_hi, sel_bits;

    assign span = {{BYTES{1'b0}}, fld_bytes} << ofs;

    for (genvar g = 0; g < BYTES; g++) begin : g_bits
        assign clr_lo[g*8 +: 8]   = {8{span[g]}};
        assign clr_hi[g*8 +: 8]   = {8{span[BYTES+g]}};
        assign sel_bits[g*8 +: 8] = {8{sel_bytes[g]}};
    end

    assign msk_lo  = a & ~clr_lo;
    assign msk_hi  = a & ~clr_hi;
    assign zap     = a & ~sel_bits;
    assign zap_not = a & sel_bits;

endmodule

// File: rtl/bmx_extins.sv
module bmx_extins #(
    parameter int DATA_W = 64,
    localparam int BYTES = DATA_W / 8,
    localparam int OFS_W = $clog2(BYTES),
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] a,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] fld_bits,
    output logic [DATA_W-1:0] ext_lo,
    output logic [DATA_W-1:0] ext_hi,
    output logic [DATA_W-1:0] ins_lo,
    output logic [DATA_W-1:0] ins_hi
);

    logic [SH_W-1:0]     bsh;
    logic [SH_W-1:0]     bsh_neg;
    logic [2*DATA_W-1:0] ins_w;

    assign bsh     = SH_W'({ofs, 3'b000});
    assign bsh_neg = SH_W'(0) - bsh;   // (width - 8*ofs) mod width

    assign ext_lo = (a >> bsh) & fld_bits;
    assign ext_hi = (a << bsh_neg) & fld_bits;

    assign ins_w  = {{DATA_W{1'b0}}, (a & fld_bits)} << bsh;
    assign ins_lo = ins_w[DATA_W-1:0];
    assign ins_hi = ins_w[2*DATA_W-1:DATA_W];

endmodule

// File: rtl/bmx_unit.sv
module bmx_unit
    import bmx_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int BYTES = DATA_W / 8,
    localparam int OFS_W = $clog2(BYTES),
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        func_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [7:0]        lit_i,
    input  logic              use_lit_i,
    output logic [DATA_W-1:0] result_o,
    output logic              illegal_o
);

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              ill;
    } out_t;

    out_t st_d, st_q;

    logic [DATA_W-1:0] b_eff;
    logic [OFS_W-1:0]  ofs;
    logic [SH_W-1:0]   shamt;
    logic [BYTES-1:0]  sel_bytes;
    logic              unused_b_hi;

    assign b_eff       = use_lit_i ? DATA_W'(lit_i) : b_i;
    assign ofs         = b_eff[OFS_W-1:0];
    assign shamt       = b_eff[SH_W-1:0];
    assign sel_bytes   = b_eff[BYTES-1:0];
    assign unused_b_hi = ^b_eff[DATA_W-1:SH_W];

    dec_t dec;

    bmx_decode u_dec (
        .func (func_i),
        .dec  (dec)
    );

    logic [BYTES-1:0]  fld_bytes;
    logic [DATA_W-1:0] fld_bits;

    bmx_szmask #(.DATA_W(DATA_W)) u_sz (
        .size      (dec.size),
        .byte_mask (fld_bytes),
        .bit_mask  (fld_bits)
    );

    logic [DATA_W-1:0] msk_lo, msk_hi, zap, zap_not;

    bmx_bytemask #(.DATA_W(DATA_W)) u_msk (
        .a         (a_i),
        .ofs       (ofs),
        .fld_bytes (fld_bytes),
        .sel_bytes (sel_bytes),
        .msk_lo    (msk_lo),
        .msk_hi    (msk_hi),
        .zap       (zap),
        .zap_not   (zap_not)
    );

    logic [DATA_W-1:0] ext_lo, ext_hi, ins_lo, ins_hi;

    bmx_extins #(.DATA_W(DATA_W)) u_ei (
        .a        (a_i),
        .ofs      (ofs),
        .fld_bits (fld_bits),
        .ext_lo   (ext_lo),
        .ext_hi   (ext_hi),
        .ins_lo   (ins_lo),
        .ins_hi   (ins_hi)
    );

    always_comb begin
        st_d = '0;
        case (dec.kind)
            K_SLL:   st_d.res = a_i << shamt;
            K_SRL:   st_d.res = a_i >> shamt;
            K_SRA:   st_d.res = DATA_W'($signed(a_i) >>> shamt);
            K_MSKL:  st_d.res = msk_lo;
            K_MSKH:  st_d.res = msk_hi;
            K_EXTL:  st_d.res = ext_lo;
            K_EXTH:  st_d.res = ext_hi;
            K_INSL:  st_d.res = ins_lo;
            K_INSH:  st_d.res = ins_hi;
            K_ZAP:   st_d.res = zap;
            K_ZAPN:  st_d.res = zap_not;
            default: st_d.ill = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o  = st_q.res;
    assign illegal_o = st_q.ill;

endmodule

// File: rtl/bmx_unit_chk.sv
module bmx_unit_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [6:0]        func_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic [7:0]        lit_i,
    input logic              use_lit_i,
    input logic [DATA_W-1:0] result_o,
    input logic              illegal_o
);

    logic [7:0] low_b;
    logic       unused_chk;

    assign low_b      = use_lit_i ? lit_i : b_i[7:0];
    assign unused_chk = ^b_i[DATA_W-1:8];

    assert_rst_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (result_o == '0 && !illegal_o));

    assert_shl_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (func_i == 7'h39 && low_b[5:0] == 6'd0) |=> result_o == $past(a_i));

    assert_mskh_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((func_i == 7'h52 || func_i == 7'h62 || func_i == 7'h72) && low_b[2:0] == 3'd0)
        |=> result_o == $past(a_i));

    assert_insh_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((func_i == 7'h57 || func_i == 7'h67 || func_i == 7'h77) && low_b[2:0] == 3'd0)
        |=> result_o == '0);

    assert_zap_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (func_i == 7'h30 && low_b == 8'hff) |=> result_o == '0);

    assert_zapnot_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (func_i == 7'h31 && low_b == 8'hff) |=> result_o == $past(a_i));

    assert_illegal_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> result_o == '0);

    assert_shift_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (func_i == 7'h39 || func_i == 7'h34 || func_i == 7'h3c) |=> !illegal_o);

endmodule

bind bmx_unit bmx_unit_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .func_i    (func_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .lit_i     (lit_i),
    .use_lit_i (use_lit_i),
    .result_o  (result_o),
    .illegal_o (illegal_o)
);

// File: tb/bmx_unit_tb_top.sv
`timescale 1ns/1ps
module bmx_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  func_i = 7'h7f;
    logic [63:0] a_i = '0;
    logic [63:0] b_i = '0;
    logic [7:0]  lit_i = '0;
    logic        use_lit_i = 1'b0;
    logic [63:0] result_o;
    logic        illegal_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    bmx_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .func_i    (func_i),
        .a_i       (a_i),
        .b_i       (b_i),
        .lit_i     (lit_i),
        .use_lit_i (use_lit_i),
        .result_o  (result_o),
        .illegal_o (illegal_o)
    );

    typedef struct {
        logic [63:0] res;
        logic        ill;
        logic [6:0]  f;
        string       tag;
    } item_t;

    item_t sb_q[$];

    function automatic string req_of(input logic [6:0] f);
        case (f)
            7'h39, 7'h34, 7'h3c:        return "R2";
            7'h02, 7'h12, 7'h22, 7'h32: return "R3";
            7'h52, 7'h62, 7'h72:        return "R4";
            7'h06, 7'h16, 7'h26, 7'h36: return "R5";
            7'h5a, 7'h6a, 7'h7a:        return "R6";
            7'h0b, 7'h1b, 7'h2b, 7'h3b: return "R7";
            7'h57, 7'h67, 7'h77:        return "R8";
            7'h30, 7'h31:               return "R9";
            default:                    return "R11";
        endcase
    endfunction

    // Behavioural model written from the requirement text.
    function automatic logic [64:0] model(input logic [6:0] f,
                                          input logic [63:0] a,
                                          input logic [63:0] b);
        logic [63:0] fm, r;
        int ofs, bs, sh;
        logic ill;
        ofs = int'(b[2:0]);
        bs  = ofs * 8;
        sh  = int'(b[5:0]);
        ill = 1'b0;
        r   = '0;
        case (f[5:4])
            2'd0:    fm = 64'h0000_0000_0000_00ff;
            2'd1:    fm = 64'h0000_0000_0000_ffff;
            2'd2:    fm = 64'h0000_0000_ffff_ffff;
            default: fm = 64'hffff_ffff_ffff_ffff;
        endcase
        case (f)
            7'h39: r = a << sh;
            7'h34: r = a >> sh;
            7'h3c: r = $signed(a) >>> sh;
            7'h02, 7'h12, 7'h22, 7'h32: r = a & ~(fm << bs);
            7'h52, 7'h62, 7'h72: r = (ofs == 0) ? a : (a & ~(fm >> (64 - bs)));
            7'h06, 7'h16, 7'h26, 7'h36: r = (a >> bs) & fm;
            7'h5a, 7'h6a, 7'h7a: r = (a << ((64 - bs) % 64)) & fm;
            7'h0b, 7'h1b, 7'h2b, 7'h3b: r = (a & fm) << bs;
            7'h57, 7'h67, 7'h77: r = (ofs == 0) ? 64'd0 : ((a & fm) >> (64 - bs));
            7'h30, 7'h31: begin
                r = a;
                for (int i = 0; i < 8; i++) begin
                    if (b[i] == (f == 7'h30)) r[i*8 +: 8] = 8'h00;
                end
            end
            default: ill = 1'b1;
        endcase
        return {ill, r};
    endfunction

    task automatic issue(input logic [6:0] f, input logic [63:0] a,
                         input logic [63:0] b, input logic [7:0] lit,
                         input logic ul);
        item_t it;
        logic [64:0] m;
        logic [63:0] beff;
        @(negedge clk);
        func_i    = f;
        a_i       = a;
        b_i       = b;
        lit_i     = lit;
        use_lit_i = ul;
        beff = ul ? {56'd0, lit} : b;
        m = model(f, a, beff);
        it.res = m[63:0];
        it.ill = m[64];
        it.f   = f;
        it.tag = ul ? {req_of(f), " R10"} : req_of(f);
        sb_q.push_back(it);
    endtask

    // Monitor: result is registered, so it is read just after the edge
    // that captured the inputs issued on the previous falling edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_cmp++;
                if (result_o !== it.res || illegal_o !== it.ill) begin
                    n_bad++;
                    $display("FAIL %s func=%h result=%h/%b expected=%h/%b",
                             it.tag, it.f, result_o, illegal_o, it.res, it.ill);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    logic [6:0] codes [25] = '{
        7'h39, 7'h34, 7'h3c,
        7'h02, 7'h12, 7'h22, 7'h32,
        7'h52, 7'h62, 7'h72,
        7'h06, 7'h16, 7'h26, 7'h36,
        7'h5a, 7'h6a, 7'h7a,
        7'h0b, 7'h1b, 7'h2b, 7'h3b,
        7'h57, 7'h67, 7'h77,
        7'h42
    };

    initial begin
        logic [63:0] pats [3];
        pats[0] = 64'h0123_4567_89ab_cdef;
        pats[1] = 64'hf0e1_d2c3_b4a5_9687;
        pats[2] = {$urandom, $urandom};

        // R1: reset holds outputs at zero even with an illegal code applied
        repeat (3) @(negedge clk);
        n_cmp++;
        if (result_o !== 64'd0 || illegal_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset result=%h/%b expected=%h/%b",
                     result_o, illegal_o, 64'd0, 1'b0);
        end
        rst_n = 1'b1;

        // Every code at every byte offset with three operand patterns
        for (int c = 0; c < 25; c++) begin
            for (int o = 0; o < 8; o++) begin
                for (int p = 0; p < 3; p++) begin
                    logic [63:0] b;
                    b = {$urandom, $urandom};
                    b[2:0] = 3'(o);
                    issue(codes[c], pats[p], b, 8'h00, 1'b0);
                end
                // R10: literal mode with garbage on the register operand
                begin
                    logic [7:0] l;
                    l = 8'($urandom);
                    l[2:0] = 3'(o);
                    issue(codes[c], pats[o % 3], {$urandom, $urandom}, l, 1'b1);
                end
            end
        end

        // R2: full shift count sweep
        for (int s = 0; s < 64; s++) begin
            issue(7'h39, pats[1], 64'(s), 8'h00, 1'b0);
            issue(7'h34, pats[1], 64'(s), 8'h00, 1'b0);
            issue(7'h3c, pats[1], 64'(s), 8'h00, 1'b0);
        end

        // R9: byte selectors empty, full, alternating, random
        for (int z = 0; z < 2; z++) begin
            logic [6:0] fz;
            fz = (z == 0) ? 7'h30 : 7'h31;
            issue(fz, pats[0], 64'hffff_ff00, 8'h00, 1'b0);
            issue(fz, pats[0], 64'h0000_00ff, 8'h00, 1'b0);
            issue(fz, pats[2], 64'hdead_005a, 8'h00, 1'b0);
            issue(fz, pats[1], {$urandom, $urandom}, 8'h00, 1'b0);
            issue(fz, pats[1], 64'h0, 8'ha5, 1'b1);
        end

        // R11: undefined codes next to legal ones
        issue(7'h4a, pats[0], 64'h3, 8'h00, 1'b0);
        issue(7'h47, pats[1], 64'h5, 8'h00, 1'b0);
        issue(7'h7f, pats[2], 64'h1, 8'h00, 1'b0);
        issue(7'h00, pats[0], 64'h0, 8'h00, 1'b0);

        wait (sb_q.size() == 0);
        repeat (3) @(posedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule